// File: doc/BRIEF.md
# Bus Source Handshake Controller

This block runs the talking side of the three-wire byte handshake on an 8-bit parallel instrument bus. An upstream byte source offers a next byte, either a data byte carrying an end flag or an interface command. The block presents that byte on the data lines and raises the data-valid line once the lines have settled and every listener is ready for data. It then waits for the listeners to report that the byte was accepted, and strobes the source to consume the byte.

The handshake runs only while the current role permits it. With attention asserted, only an active or transferring controller may send. With attention released, only an active talker, a serial-poll reply or a pending identify byte may send. Any other combination forces the machine back to idle at once. The settling time is a count of clock cycles. All bus lines are active-high at the block boundary, so the open-collector inversion belongs outside the block.

Top module: `src_handshake`

## Requirements
- R1: While reset is asserted and after it is released with no role qualifier active, dav_o, dio_o, eoi_o and consume_o are all 0.
- R2: When atn_i is 1 and neither ctrl_act_i nor ctrl_xfer_i is 1, the machine returns to idle at the next clock edge. dav_o is then 0, and no consume is signalled in that cycle or the one after it.
- R3: When atn_i is 0 and none of talk_act_i, spoll_act_i and ident_i is 1, the machine returns to idle at the next clock edge, and no consume is signalled.
- R4: From idle, and when not forced, the machine enters the generate state at the next edge if talk_act_i, spoll_act_i, ident_i or ctrl_act_i is 1. ctrl_xfer_i alone keeps it idle, and it drives nothing even when a byte is available.
- R5: In the generate state, nba_i = 1 moves the machine to the delay state at the next edge. From that cycle until the transfer ends, dio_o carries the byte.
- R6: The machine stays in the delay state for at least DELAY_CYC cycles. It moves to transfer only at an edge where the settle count has elapsed and nrfd_i is 0.
- R7: dav_o is 1 exactly while the machine is in the transfer state. It stays 1 until an edge at which ndac_i is 0.
- R8: consume_o is 1 for the single cycle in which the machine is in transfer, ndac_i is 0 and no forced return to idle applies. The next edge returns the machine to generate.
- R9: When nba_cmd_i = 1, dio_o[6:0] equals nba_data_i[6:0], and dio_o[7] is set exactly when that makes the 8-bit value have an odd number of ones. eoi_o stays 0 whatever nba_end_i is.
- R10: For a data byte (nba_cmd_i = 0), dio_o equals nba_data_i and eoi_o equals nba_end_i in the delay and transfer states. Outside those states, dio_o and eoi_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| atn_i | input | 1 | Bus attention line |
| talk_act_i | input | 1 | Talker active qualifier |
| spoll_act_i | input | 1 | Serial-poll reply active qualifier |
| ident_i | input | 1 | Identify byte pending qualifier |
| ctrl_act_i | input | 1 | Controller active qualifier |
| ctrl_xfer_i | input | 1 | Controller transfer (handing off) qualifier |
| nba_i | input | 1 | Source offers a next byte |
| nba_cmd_i | input | 1 | Offered byte is an interface command |
| nba_end_i | input | 1 | End flag of offered data byte |
| nba_data_i | input | DW | Offered byte value |
| nrfd_i | input | 1 | Some listener not ready for data |
| ndac_i | input | 1 | Some listener has not accepted data |
| dav_o | output | 1 | Data valid |
| dio_o | output | DW | Bus data lines |
| eoi_o | output | 1 | End line |
| consume_o | output | 1 | One-cycle strobe: source may drop the byte |

## Verification
On every cycle, the assertions check that the role conditions force an idle return with no stray consume, and that data-valid rises only after a full settle window with ready-for-data low. They also check that commands reach the lines with odd parity and no end flag, that the lines stay clear outside delay and transfer, and that consume appears only while data-valid is up and is never repeated. The bench's scenarios are the only place where some behaviours show. One is the exact cycle of each state change against a reference model, with listener latency and a long not-ready hold. Another is the order and value of bytes consumed across talker, serial-poll, identify and controller modes. The last is that a byte cut off by a forced idle stays with the source.

// File: rtl/sh_pkg.sv
package sh_pkg;
  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_GEN  = 2'd1,
    SH_DLY  = 2'd2,
    SH_XFER = 2'd3
  } sh_state_e;
endpackage

// File: rtl/sh_byte_enc.sv
module sh_byte_enc #(
  parameter int DW = 8
) (
  input  logic          on_i,
  input  logic          cmd_i,
  input  logic          end_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] dio_o,
  output logic          eoi_o
);
  logic par_bit;

  // top bit makes the whole command word odd
  assign par_bit = ~(^data_i[DW-2:0]);

  always_comb begin
    dio_o = '0;
    eoi_o = 1'b0;
    if (on_i) begin
      if (cmd_i) begin
        dio_o = {par_bit, data_i[DW-2:0]};
      end else begin
        dio_o = data_i;
        eoi_o = end_i;
      end
    end
  end
endmodule

// File: rtl/sh_settle_tmr.sv
module sh_settle_tmr #(
  parameter int CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sh_fsm.sv
module sh_fsm
  import sh_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      force_i,
  input  logic      go_i,
  input  logic      nba_i,
  input  logic      nrfd_i,
  input  logic      ndac_i,
  input  logic      done_i,
  output sh_state_e state_o,
  output logic      load_o,
  output logic      consume_o
);
  sh_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    load_o    = 1'b0;
    consume_o = 1'b0;
    if (force_i) begin
      st_d = SH_IDLE;
    end else begin
      unique case (st_q)
        SH_IDLE: if (go_i) st_d = SH_GEN;
        SH_GEN: if (nba_i) begin
          st_d   = SH_DLY;
          load_o = 1'b1;
        end
        SH_DLY: if (done_i && !nrfd_i) st_d = SH_XFER;
        SH_XFER: if (!ndac_i) begin
          st_d      = SH_GEN;
          consume_o = 1'b1;
        end
        default: st_d = SH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SH_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/src_handshake.sv
module src_handshake
  import sh_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DELAY_CYC = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          atn_i,
  input  logic          talk_act_i,
  input  logic          spoll_act_i,
  input  logic          ident_i,
  input  logic          ctrl_act_i,
  input  logic          ctrl_xfer_i,
  input  logic          nba_i,
  input  logic          nba_cmd_i,
  input  logic          nba_end_i,
  input  logic [DW-1:0] nba_data_i,
  input  logic          nrfd_i,
  input  logic          ndac_i,
  output logic          dav_o,
  output logic [DW-1:0] dio_o,
  output logic          eoi_o,
  output logic          consume_o
);
  sh_state_e state;
  logic      talk_side, force_idle, go, load, tmr_done, dly_st, lines_on;

  assign talk_side  = talk_act_i | spoll_act_i | ident_i;
  assign force_idle = atn_i ? ~(ctrl_act_i | ctrl_xfer_i) : ~talk_side;
  assign go         = talk_side | ctrl_act_i;
  assign dly_st     = (state == SH_DLY);
  assign lines_on   = dly_st | (state == SH_XFER);

  sh_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .force_i   (force_idle),
    .go_i      (go),
    .nba_i     (nba_i),
    .nrfd_i    (nrfd_i),
    .ndac_i    (ndac_i),
    .done_i    (tmr_done),
    .state_o   (state),
    .load_o    (load),
    .consume_o (consume_o)
  );

  sh_settle_tmr #(.CYC(DELAY_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .run_i  (dly_st),
    .done_o (tmr_done)
  );

  sh_byte_enc #(.DW(DW)) u_enc (
    .on_i   (lines_on),
    .cmd_i  (nba_cmd_i),
    .end_i  (nba_end_i),
    .data_i (nba_data_i),
    .dio_o  (dio_o),
    .eoi_o  (eoi_o)
  );

  assign dav_o = (state == SH_XFER);
endmodule

// File: rtl/sh_checker.sv
module sh_checker #(
  parameter int DW        = 8,
  parameter int DELAY_CYC = 100
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          atn_i,
  input logic          talk_act_i,
  input logic          spoll_act_i,
  input logic          ident_i,
  input logic          ctrl_act_i,
  input logic          ctrl_xfer_i,
  input logic          nba_cmd_i,
  input logic          nrfd_i,
  input logic          ndac_i,
  input logic          dav_o,
  input logic [DW-1:0] dio_o,
  input logic          eoi_o,
  input logic          consume_o,
  input logic          in_dly
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  logic [CW-1:0] dly_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          dly_seen <= '0;
    else if (!in_dly)                     dly_seen <= '0;
    else if (dly_seen != CW'(DELAY_CYC))  dly_seen <= dly_seen + 1'b1;
  end

  a_r2_atn_forces_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (atn_i && !ctrl_act_i && !ctrl_xfer_i) |=> (!dav_o && !consume_o));

  a_r2_no_consume_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (atn_i && !ctrl_act_i && !ctrl_xfer_i) |-> !consume_o);

  a_r3_noatn_forces_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!atn_i && !talk_act_i && !spoll_act_i && !ident_i) |=> (!dav_o && !consume_o));

  a_r6_settle_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dav_o) |-> (dly_seen == CW'(DELAY_CYC) && !$past(nrfd_i)));

  a_r8_consume_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_o |-> (dav_o && !ndac_i));

  a_r8_consume_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_o |=> (!consume_o && !dav_o));

  a_r7_dav_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dav_o && ndac_i && !$fell(dav_o)) |=> (dav_o || !rst_ni ||
      $past(atn_i ? !(ctrl_act_i || ctrl_xfer_i) : !(talk_act_i || spoll_act_i || ident_i))));

  a_r9_cmd_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dav_o && nba_cmd_i) |-> ((^dio_o) && !eoi_o));

  a_r10_lines_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dav_o && !in_dly) |-> (dio_o == '0 && !eoi_o));
endmodule

bind src_handshake sh_checker #(.DW(DW), .DELAY_CYC(DELAY_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .atn_i       (atn_i),
  .talk_act_i  (talk_act_i),
  .spoll_act_i (spoll_act_i),
  .ident_i     (ident_i),
  .ctrl_act_i  (ctrl_act_i),
  .ctrl_xfer_i (ctrl_xfer_i),
  .nba_cmd_i   (nba_cmd_i),
  .nrfd_i      (nrfd_i),
  .ndac_i      (ndac_i),
  .dav_o       (dav_o),
  .dio_o       (dio_o),
  .eoi_o       (eoi_o),
  .consume_o   (consume_o),
  .in_dly      (dly_st)
);

// File: tb/src_handshake_test.sv
`timescale 1ns/1ps
module src_handshake_test;
  localparam int DW  = 8;
  localparam int DLY = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic atn = 0, tact = 0, sp = 0, idf = 0, cact = 0, cxfer = 0;
  logic nba = 0, ncmd = 0, nend = 0;
  logic [DW-1:0] ndata = '0;
  logic nrfd = 1, ndac = 1;
  logic dav, eoi, cons;
  logic [DW-1:0] dio;

  always #10 clk = ~clk;

  src_handshake #(.DW(DW), .DELAY_CYC(DLY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .atn_i(atn), .talk_act_i(tact),
    .spoll_act_i(sp), .ident_i(idf), .ctrl_act_i(cact), .ctrl_xfer_i(cxfer),
    .nba_i(nba), .nba_cmd_i(ncmd), .nba_end_i(nend), .nba_data_i(ndata),
    .nrfd_i(nrfd), .ndac_i(ndac), .dav_o(dav), .dio_o(dio), .eoi_o(eoi),
    .consume_o(cons)
  );

  int vecs = 0, errs = 0;
  // source queue items: {cmd, end, data}
  logic [9:0] src_q[$];
  logic [8:0] exp_q[$];   // {eoi, dio}
  logic src_en = 1;
  logic hold_nrfd = 0;
  int acc_lat = 2, dav_cnt = 0;

  // reference model
  int m_st = 0, m_wait = 0;
  logic m_dav, m_eoi, m_cons;
  logic [DW-1:0] m_dio;

  function automatic logic [DW-1:0] enc(input logic cmd, input logic [DW-1:0] d);
    int ones = 0;
    for (int i = 0; i < DW-1; i++) if (d[i]) ones++;
    if (!cmd) return d;
    return {(ones % 2 == 0) ? 1'b1 : 1'b0, d[DW-2:0]};
  endfunction

  function automatic logic m_force();
    if (atn) return !(cact || cxfer);
    return !(tact || sp || idf);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic cmd, input logic e, input logic [DW-1:0] d);
    src_q.push_back({cmd, e, d});
    exp_q.push_back({(!cmd && e), enc(cmd, d)});
  endtask

  task automatic step();
    logic on;
    @(posedge clk);
    if (!rst_n) begin
      m_st = 0; m_wait = 0;
    end else if (m_force()) begin
      m_st = 0;
    end else begin
      case (m_st)
        0: if (tact || sp || idf || cact) m_st = 1;
        1: if (nba) begin m_st = 2; m_wait = 0; end
        2: if (m_wait >= DLY-1 && !nrfd) m_st = 3; else m_wait++;
        default: if (!ndac) begin
          m_st = 1;
          void'(src_q.pop_front());
        end
      endcase
    end
    @(negedge clk);
    // acceptor
    if (!dav) begin ndac = 1; dav_cnt = 0; nrfd = hold_nrfd; end
    else begin nrfd = 1; dav_cnt++; if (dav_cnt >= acc_lat) ndac = 0; end
    // source
    nba = src_en && (src_q.size() > 0);
    if (src_q.size() > 0) {ncmd, nend, ndata} = src_q[0];
    else begin ncmd = 0; nend = 0; ndata = '0; end
    #1;
    on     = (m_st == 2) || (m_st == 3);
    m_dav  = (m_st == 3);
    m_dio  = on ? enc(ncmd, ndata) : '0;
    m_eoi  = on && !ncmd && nend;
    m_cons = (m_st == 3) && !ndac && !m_force() && rst_n;
    chk(dav == m_dav, "R6,R7 dav", dav, m_dav);
    chk(dio == m_dio, ncmd ? "R9 dio" : "R10 dio", dio, m_dio);
    chk(eoi == m_eoi, ncmd ? "R9 eoi" : "R10 eoi", eoi, m_eoi);
    chk(cons == m_cons, "R8 consume", cons, m_cons);
    if (cons) begin
      if (exp_q.size() == 0) chk(0, "R5 extra byte", {eoi, dio}, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({eoi, dio} == e, "R5 byte value", {eoi, dio}, e);
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain(input int lim);
    for (int i = 0; i < lim && src_q.size() > 0; i++) step();
    chk(src_q.size() == 0, "R8 drained", src_q.size(), 0);
    chk(exp_q.size() == 0, "R5 all consumed", exp_q.size(), 0);
  endtask

  task automatic set_role(input logic a, input logic t, input logic s, input logic i,
                          input logic c, input logic x);
    atn = a; tact = t; sp = s; idf = i; cact = c; cxfer = x;
  endtask

  initial begin
    #4ms;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    run(3);
    // R1: reset state
    chk(!dav && dio == 0 && !eoi && !cons, "R1 reset", {dav, dio, eoi, cons}, 0);
    rst_n = 1;
    run(5);
    chk(!dav && dio == 0 && !cons, "R1 idle after reset", {dav, dio, cons}, 0);

    // R4, R5, R6: talker data bytes; listeners hold not-ready past the settle window
    set_role(0, 1, 0, 0, 0, 0);
    hold_nrfd = 1; acc_lat = 3;
    push(0, 0, 8'h5A); push(0, 1, 8'h00); push(0, 0, 8'hFF);
    run(150);
    chk(!dav, "R6 nrfd holds", dav, 0);
    hold_nrfd = 0;
    drain(2000);

    // R9: controller commands, end flag must not show
    set_role(1, 0, 0, 0, 1, 0);
    acc_lat = 1;
    push(1, 0, 8'h3F); push(1, 0, 8'h01); push(1, 1, 8'h14); push(1, 0, 8'h7F);
    drain(2000);

    // R7: slow acceptor, serial poll reply then identify bytes
    set_role(0, 0, 1, 0, 0, 0);
    acc_lat = 20;
    push(0, 0, 8'h40);
    drain(1000);
    set_role(0, 0, 0, 1, 0, 0);
    acc_lat = 2;
    push(0, 0, 8'hA5); push(0, 1, 8'h3C);
    drain(1000);

    // R2: attention raised mid transfer with no controller role
    set_role(0, 1, 0, 0, 0, 0);
    acc_lat = 60;
    push(0, 0, 8'h11);
    for (int i = 0; i < 400 && !dav; i++) step();
    chk(dav, "R2 reached transfer", dav, 1);
    run(3);
    atn = 1;
    run(3);
    chk(!dav && dio == 0, "R2 forced idle", {dav, dio}, 0);
    chk(src_q.size() == 1, "R2 byte kept", src_q.size(), 1);
    src_q.delete(); exp_q.delete();
    run(2);

    // R3: talker role dropped during the settle delay
    set_role(0, 1, 0, 0, 0, 0);
    acc_lat = 2;
    run(3);
    push(0, 0, 8'h22);
    run(20);
    tact = 0;
    run(3);
    chk(!dav && dio == 0, "R3 forced idle", {dav, dio}, 0);
    chk(src_q.size() == 1, "R3 byte kept", src_q.size(), 1);

    // R4: controller-transfer alone keeps the machine idle
    set_role(1, 0, 0, 0, 0, 1);
    run(150);
    chk(!dav && dio == 0 && src_q.size() == 1, "R4 xfer only idle", {dav, dio}, 0);
    // R4: then controller active sends it
    exp_q.delete(); src_q.delete();
    push(0, 1, 8'h33);
    set_role(1, 0, 0, 0, 1, 0);
    drain(1000);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule